// File: doc/BRIEF.md
# DMA Channel Reload-Mode Address and Count Controller

This block keeps the address and count state of a single DMA channel. It holds working source and destination addresses, a backup base address for each, a total transfer counter and a combined block register. The block register packs a reload value in one field and a running block count in another. Each transfer request that the block accepts issues one transfer on `xfer_go` and presents the current source and destination addresses. On the same clock edge the block advances both addresses and decrements the counters.

In reload mode, a block ends when its running count is spent. At that point the working addresses return to their base values and the block count is refilled from the reload field. This repeats until the total counter reaches zero, with no software action between blocks. In any other mode the block register is left alone and the addresses only ever advance. Two sticky flags report when the transfer is half done and when it has ended.

Software programs the channel through a single-cycle write port. The address and count registers accept writes only while the channel is disabled.

Top module: `dma_reload_chan`

## Requirements
- R1: After a synchronous active-low reset, all working and base addresses are zero, the total counter is zero, the block register is zero, both flags are clear and the channel is disabled.
- R2: A write selects its register by `cfg_sel`. The codes are: 0 control, 1 working source, 2 working destination, 3 source base, 4 destination base, 5 total count (bits [23:0]), 6 block register. The control register is always writable. Writes to codes 1 to 6 are ignored while the channel is enabled.
- R3: The control register layout is: bit 0 enable, bits [2:1] mode, bits [4:3] source step, bits [6:5] destination step. A request is accepted only while the channel is enabled and the total counter is nonzero. An accepted request raises `xfer_go` in the same cycle, with `xfer_src` and `xfer_dst` showing the addresses that this transfer uses. A request that is not accepted changes no state.
- R4: Each accepted request decrements the total counter by one.
- R5: Each address advances after an accepted request by its own step code: 0 holds, 1 adds 1, 2 adds 2, 3 adds 4.
- R6: Reload mode is mode code 01. In this mode, each accepted request decrements the block count in bits [7:0]. When the block count was 1 or 0 and the transfer is not the last one, the block ends: both working addresses are loaded from their base registers, and bits [23:16] are copied into bits [7:0]. Bits [23:16] never change on a transfer.
- R7: In any mode other than 01, the block register is not touched by transfers, and the addresses are never restored from their bases.
- R8: `xfer_end` sets on the edge where the total counter goes from 1 to 0. It stays set until the total count is written again.
- R9: `half_end` sets on the edge where the total counter becomes the programmed start value shifted right by one. It stays set until the total count is written again.
- R10: When a block ends on the same transfer that brings the total counter to zero, no reload takes place. The addresses advance by their steps, and the block count ends at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Register write data |
| xfer_req | input | 1 | Transfer request |
| xfer_go | output | 1 | Transfer issued this cycle |
| xfer_src | output | 32 | Working source address |
| xfer_dst | output | 32 | Working destination address |
| mon_count | output | 24 | Total transfer counter |
| mon_reload | output | 32 | Block register: reload value [23:16], block count [7:0] |
| half_end | output | 1 | Half-transfer flag |
| xfer_end | output | 1 | Transfer-end flag |
| chan_on | output | 1 | Channel enable bit |

## Verification
The bench targets the transfer where the block finishes and the total counter also reaches zero. A design that let the reload win there would jump the source address back to its base and refill the block count, where the addresses should simply advance. It also covers a block count that starts at zero. Treating that as 256 transfers would make the first block far too long. Register writes attempted while the channel runs are checked too: a missing lock would let a stray write move an address in the middle of a block. Finally, requests sent after the counter hits zero must not issue a transfer or wrap the counter.

// File: rtl/dma_reload_pkg.sv
// Shared types and helpers for the reload-mode DMA channel controller.
// Assumes a single channel with one register write port.
package dma_reload_pkg;

    localparam int SEL_W  = 3;
    localparam int CTRL_W = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL     = 3'd0,
        SEL_SRC      = 3'd1,
        SEL_DST      = 3'd2,
        SEL_SRC_BASE = 3'd3,
        SEL_DST_BASE = 3'd4,
        SEL_TOTAL    = 3'd5,
        SEL_BLOCK    = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2,
        STEP_FOUR = 2'd3
    } step_e;

    localparam logic [1:0] MODE_RELOAD = 2'b01;

    // Control word, MSB first: dst step, src step, mode, enable
    typedef struct packed {
        logic [1:0] dst_step;
        logic [1:0] src_step;
        logic [1:0] mode;
        logic       en;
    } ctrl_t;

    // Byte increment for a step code
    function automatic logic [2:0] step_bytes(input step_e s);
        case (s)
            STEP_ONE:  return 3'd1;
            STEP_TWO:  return 3'd2;
            STEP_FOUR: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_ctrl_regs.sv
// Channel control register: enable, mode and per-address step codes.
// Assumes the write strobe is already decoded for this register; it is
// writable at any time, including while the channel runs.
module dma_ctrl_regs
    import dma_reload_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    // Hold the control word; reset leaves the channel disabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en)
            ctrl <= ctrl_t'(wr_data);
    end

endmodule

// File: rtl/dma_addr_unit.sv
// One address channel: a working address and its base copy. The working
// address advances by a step code on each transfer, or is restored from
// the base when a block ends. Assumes software writes and transfers never
// coincide (writes are only passed through while the channel is disabled).
module dma_addr_unit
    import dma_reload_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_work,
    input  logic              wr_base,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        step,
    input  logic              advance,
    input  logic              restore,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] inc;

    // Byte increment chosen by the step code
    always_comb inc = ADDR_W'(step_bytes(step_e'(step)));

    // Working address: software load, restore at block end, or step
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (wr_work)
            addr <= wr_data;
        else if (advance)
            addr <= restore ? base : addr + inc;
    end

    // Base copy used for restores
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (wr_base)
            base <= wr_data;
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restore && !wr_work) |=> addr == $past(addr) + $past(inc));

    // R6
    addr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && restore && !wr_work) |=> addr == $past(base));

endmodule

// File: rtl/dma_count_unit.sv
// Total counter, block register (reload value plus running block count)
// and the half and end flags. Signals a restore when a block ends on a
// transfer that is not the last. Assumes RV_LSB >= BLK_W so the two block
// fields do not overlap.
module dma_count_unit #(
    parameter int CNT_W  = 24,
    parameter int BLK_W  = 8,
    parameter int RV_LSB = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_total,
    input  logic [CNT_W-1:0]        wr_count,
    input  logic                    wr_block,
    input  logic [BLK_W-1:0]        wr_blk,
    input  logic [BLK_W-1:0]        wr_rv,
    input  logic                    accept,
    input  logic                    reload_mode,
    output logic [CNT_W-1:0]        cnt,
    output logic [RV_LSB+BLK_W-1:0] block_view,
    output logic                    cnt_zero,
    output logic                    restore,
    output logic                    half_end,
    output logic                    xfer_end
);

    localparam int GAP_W = RV_LSB - BLK_W;

    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] rv;
    logic [CNT_W-1:0] half_thr;
    logic [CNT_W-1:0] cnt_dec;
    logic             last;
    logic             blk_done;

    // Decode the end-of-block and last-transfer conditions
    always_comb begin
        cnt_dec  = cnt - CNT_W'(1);
        cnt_zero = (cnt == '0);
        last     = (cnt == CNT_W'(1));
        blk_done = (blk <= BLK_W'(1));
        restore  = reload_mode && blk_done && !last;
    end

    // Register view: reload value in the upper field, count in the lower
    generate
        if (GAP_W > 0) begin : g_gap
            always_comb block_view = {rv, {GAP_W{1'b0}}, blk};
        end else begin : g_nogap
            always_comb block_view = {rv, blk};
        end
    endgenerate

    // Total counter, half threshold and both flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            half_thr <= '0;
            half_end <= 1'b0;
            xfer_end <= 1'b0;
        end else if (wr_total) begin
            cnt      <= wr_count;
            half_thr <= wr_count >> 1;
            half_end <= 1'b0;
            xfer_end <= 1'b0;
        end else if (accept) begin
            cnt <= cnt_dec;
            if (last)
                xfer_end <= 1'b1;
            if (cnt_dec == half_thr)
                half_end <= 1'b1;
        end
    end

    // Block count and reload value; touched by transfers only in reload mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk <= '0;
            rv  <= '0;
        end else if (wr_block) begin
            blk <= wr_blk;
            rv  <= wr_rv;
        end else if (accept && reload_mode) begin
            if (restore)
                blk <= rv;
            else if (blk != '0)
                blk <= blk - BLK_W'(1);
        end
    end

    // R4
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_total) |=> cnt == $past(cnt) - CNT_W'(1));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !wr_total) |=> $stable(cnt));

    // R8
    end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_end) |-> cnt == '0);

    // R6
    blk_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && restore && !wr_block) |=> blk == $past(rv));

    // R7
    normal_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_mode && !wr_block) |=> $stable(blk) && $stable(rv));

    // R10
    end_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last && !wr_block) |=> blk == '0 || blk == $past(blk) - BLK_W'(1) || !$past(reload_mode));

endmodule

// File: rtl/dma_reload_chan.sv
// Top of the reload-mode DMA channel controller. Decodes the register
// write port, locks address and count registers while the channel is
// enabled, accepts transfer requests and drives both address units and
// the count unit. Assumes one request per cycle at most.
module dma_reload_chan
    import dma_reload_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24,
    parameter int BLK_W  = 8,
    parameter int RV_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              xfer_req,
    output logic              xfer_go,
    output logic [ADDR_W-1:0] xfer_src,
    output logic [ADDR_W-1:0] xfer_dst,
    output logic [CNT_W-1:0]  mon_count,
    output logic [ADDR_W-1:0] mon_reload,
    output logic              half_end,
    output logic              xfer_end,
    output logic              chan_on
);

    localparam int NUM_ADDR = 2;
    localparam int BV_W     = RV_LSB + BLK_W;

    ctrl_t             ctrl;
    logic              wr_open;
    logic              accept;
    logic              restore;
    logic              cnt_zero;
    logic              reload_mode;
    logic [BV_W-1:0]   block_view;
    logic [ADDR_W-1:0] addr_q [NUM_ADDR];

    dma_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && cfg_sel == SEL_CTRL),
        .wr_data (cfg_wdata[CTRL_W-1:0]),
        .ctrl    (ctrl)
    );

    // Register lock, mode decode and request acceptance
    always_comb begin
        wr_open     = cfg_we && !ctrl.en;
        reload_mode = (ctrl.mode == MODE_RELOAD);
        accept      = xfer_req && ctrl.en && !cnt_zero;
    end

    // Source and destination address units
    generate
        for (genvar g = 0; g < NUM_ADDR; g++) begin : g_addr
            localparam reg_sel_e WORK_SEL = (g == 0) ? SEL_SRC : SEL_DST;
            localparam reg_sel_e BASE_SEL = (g == 0) ? SEL_SRC_BASE : SEL_DST_BASE;
            dma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_work (wr_open && cfg_sel == WORK_SEL),
                .wr_base (wr_open && cfg_sel == BASE_SEL),
                .wr_data (cfg_wdata),
                .step    ((g == 0) ? ctrl.src_step : ctrl.dst_step),
                .advance (accept),
                .restore (restore),
                .addr    (addr_q[g])
            );
        end
    endgenerate

    dma_count_unit #(
        .CNT_W  (CNT_W),
        .BLK_W  (BLK_W),
        .RV_LSB (RV_LSB)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_total    (wr_open && cfg_sel == SEL_TOTAL),
        .wr_count    (cfg_wdata[CNT_W-1:0]),
        .wr_block    (wr_open && cfg_sel == SEL_BLOCK),
        .wr_blk      (cfg_wdata[BLK_W-1:0]),
        .wr_rv       (cfg_wdata[RV_LSB +: BLK_W]),
        .accept      (accept),
        .reload_mode (reload_mode),
        .cnt         (mon_count),
        .block_view  (block_view),
        .cnt_zero    (cnt_zero),
        .restore     (restore),
        .half_end    (half_end),
        .xfer_end    (xfer_end)
    );

    // Drive the outputs
    always_comb begin
        xfer_go    = accept;
        xfer_src   = addr_q[0];
        xfer_dst   = addr_q[1];
        mon_reload = ADDR_W'(block_view);
        chan_on    = ctrl.en;
    end

    // R2
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && chan_on && cfg_sel == SEL_SRC && !xfer_go) |=> $stable(xfer_src));

    // R3
    go_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> mon_count != '0 && chan_on);

endmodule

// File: tb/dma_reload_chan_test.sv
module dma_reload_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        xfer_req = 1'b0;
    logic        xfer_go;
    logic [31:0] xfer_src, xfer_dst, mon_reload;
    logic [23:0] mon_count;
    logic        half_end, xfer_end, chan_on;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference model state
    logic        m_en;
    logic [1:0]  m_mode, m_ss, m_ds;
    logic [31:0] m_src, m_dst, m_sb, m_db;
    logic [23:0] m_cnt, m_half;
    logic [7:0]  m_blk, m_rv;
    logic        m_he, m_te;

    dma_reload_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .xfer_go(xfer_go),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .mon_count(mon_count),
        .mon_reload(mon_reload), .half_end(half_end), .xfer_end(xfer_end),
        .chan_on(chan_on)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stepb(input logic [1:0] c);
        case (c)
            2'd1: return 32'd1;
            2'd2: return 32'd2;
            2'd3: return 32'd4;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic en, input logic [1:0] mode,
                                            input logic [1:0] ss, input logic [1:0] ds);
        return {25'd0, ds, ss, mode, en};
    endfunction

    task automatic model_reset();
        m_en = 0; m_mode = 0; m_ss = 0; m_ds = 0;
        m_src = 0; m_dst = 0; m_sb = 0; m_db = 0;
        m_cnt = 0; m_half = 0; m_blk = 0; m_rv = 0; m_he = 0; m_te = 0;
    endtask

    // One clock: drive, check issue outputs, update model, check state
    task automatic cyc(input logic we, input logic [2:0] sel, input logic [31:0] d, input logic req);
        logic acc, last, rest, en_old;
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = d; xfer_req = req;
        #1;
        en_old = m_en;
        acc = req && m_en && (m_cnt != 0);
        chk("R3 go", {63'd0, xfer_go}, {63'd0, acc});
        if (acc) begin
            chk("R3 issued src", {32'd0, xfer_src}, {32'd0, m_src});
            chk("R3 issued dst", {32'd0, xfer_dst}, {32'd0, m_dst});
            last = (m_cnt == 1);
            rest = (m_mode == 2'b01) && (m_blk <= 1) && !last;
            m_src = rest ? m_sb : m_src + stepb(m_ss);
            m_dst = rest ? m_db : m_dst + stepb(m_ds);
            m_cnt = m_cnt - 1;
            if (last) m_te = 1;
            if (m_cnt == m_half) m_he = 1;
            if (m_mode == 2'b01)
                m_blk = rest ? m_rv : ((m_blk == 0) ? 8'd0 : m_blk - 1);
        end
        if (we) begin
            if (sel == 3'd0) begin
                m_en = d[0]; m_mode = d[2:1]; m_ss = d[4:3]; m_ds = d[6:5];
            end else if (!en_old) begin
                case (sel)
                    3'd1: m_src = d;
                    3'd2: m_dst = d;
                    3'd3: m_sb = d;
                    3'd4: m_db = d;
                    3'd5: begin m_cnt = d[23:0]; m_half = d[23:0] >> 1; m_he = 0; m_te = 0; end
                    3'd6: begin m_blk = d[7:0]; m_rv = d[23:16]; end
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        #1;
        chk("R4 total count", {40'd0, mon_count}, {40'd0, m_cnt});
        chk("R5 R6 working src", {32'd0, xfer_src}, {32'd0, m_src});
        chk("R5 R6 working dst", {32'd0, xfer_dst}, {32'd0, m_dst});
        chk((m_mode == 2'b01) ? "R6 block register" : "R7 block register",
            {32'd0, mon_reload}, {32'd0, 8'd0, m_rv, 8'd0, m_blk});
        chk("R8 end flag", {63'd0, xfer_end}, {63'd0, m_te});
        chk("R9 half flag", {63'd0, half_end}, {63'd0, m_he});
        chk("R2 enable", {63'd0, chan_on}, {63'd0, m_en});
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        cyc(1'b1, sel, d, 1'b0);
    endtask

    task automatic setup(input logic [31:0] src, input logic [31:0] dst,
                         input logic [31:0] sb, input logic [31:0] db,
                         input logic [23:0] total, input logic [7:0] rv, input logic [7:0] blk,
                         input logic [1:0] mode, input logic [1:0] ss, input logic [1:0] ds);
        wr(3'd0, mk_ctrl(1'b0, mode, ss, ds));
        wr(3'd1, src); wr(3'd2, dst); wr(3'd3, sb); wr(3'd4, db);
        wr(3'd5, {8'd0, total});
        wr(3'd6, {8'd0, rv, 8'd0, blk});
        wr(3'd0, mk_ctrl(1'b1, mode, ss, ds));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 count", {40'd0, mon_count}, 64'd0);
        chk("R1 src", {32'd0, xfer_src}, 64'd0);
        chk("R1 block", {32'd0, mon_reload}, 64'd0);
        chk("R1 flags", {62'd0, half_end, xfer_end}, 64'd0);
        chk("R1 disabled", {63'd0, chan_on}, 64'd0);
        rst_n = 1'b1;
        cyc(1'b0, 3'd0, 32'd0, 1'b1);   // request while disabled: R3 ignored

        // R6 R9: reload returns addresses to base; half flag at floor(7/2)=3
        setup(32'h100, 32'h200, 32'h1000, 32'h2000, 24'd7, 8'd3, 8'd2, 2'b01, 2'd1, 2'd0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        chk("R6 src restored at block end", {32'd0, xfer_src}, 64'h1000);
        chk("R6 block refilled", {56'd0, mon_reload[7:0]}, 64'd3);
        cyc(0, 0, 0, 1);
        chk("R9 half not yet", {63'd0, half_end}, 64'd0);
        cyc(0, 0, 0, 1);
        chk("R9 half at three left", {63'd0, half_end}, 64'd1);

        // R2: locked writes while enabled
        wr(3'd1, 32'hDEAD_0000);
        chk("R2 locked src write", {32'd0, xfer_src}, {32'd0, m_src});
        wr(3'd5, 32'd99);
        chk("R2 locked count write", {40'd0, mon_count}, 64'd3);

        // R10: block ends with the last transfer, no reload
        setup(32'h100, 32'h200, 32'h1000, 32'h2000, 24'd4, 8'd2, 8'd4, 2'b01, 2'd3, 2'd0);
        repeat (4) cyc(0, 0, 0, 1);
        chk("R10 src advanced not restored", {32'd0, xfer_src}, 64'h110);
        chk("R10 block count zero", {56'd0, mon_reload[7:0]}, 64'd0);
        chk("R8 end set", {63'd0, xfer_end}, 64'd1);
        cyc(0, 0, 0, 1);                 // R3: request after end ignored
        chk("R3 no wrap after end", {40'd0, mon_count}, 64'd0);

        // R6: zero block count treated as an ended block
        setup(32'h40, 32'h80, 32'h400, 32'h800, 24'd5, 8'd2, 8'd0, 2'b01, 2'd2, 2'd2);
        cyc(0, 0, 0, 1);
        chk("R6 zero block restores", {32'd0, xfer_dst}, 64'h800);

        // R7: normal mode never restores
        setup(32'h10, 32'h20, 32'h900, 32'h900, 24'd6, 8'd1, 8'd1, 2'b10, 2'd1, 2'd3);
        repeat (3) cyc(0, 0, 0, 1);
        chk("R7 normal src", {32'd0, xfer_src}, 64'h13);

        // Constrained random scenarios
        for (int s = 0; s < 40; s++) begin
            logic [1:0] mode;
            mode = ($urandom % 3 == 0) ? 2'($urandom) : 2'b01;
            setup($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                  $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                  24'(1 + $urandom % 40), 8'($urandom % 6), 8'($urandom % 6),
                  mode, 2'($urandom), 2'($urandom));
            for (int c = 0; c < 60; c++) begin
                if ($urandom % 16 == 0)
                    cyc(1'b1, 3'(1 + $urandom % 6), $urandom, ($urandom % 4) != 0);
                else
                    cyc(1'b0, 3'd0, 32'd0, ($urandom % 4) != 0);
            end
        end

        cyc(0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule